// File: doc/BRIEF.md
# Guest-Aware Exception Vector Unit

This block forms the fetch address for an interrupt handler and records the effective address that faulted on the data side, in a core that keeps host and guest state apart. Each hardware thread owns a host vector base, a guest vector base, a host fault-address register and a guest fault-address register. When an exception is raised for a thread, the unit takes that thread's current guest-state bit and picks a base. It then appends a fixed 12-bit offset chosen by the exception kind and presents the result one cycle later.

When the exception is data-side (data storage, alignment or data TLB miss), the faulting address is captured. It goes into the guest fault-address register when the exception is directed to the guest, and into the host one otherwise. Privileged software reads and writes all four registers through a special-register move port. While a thread runs in guest state, the host fault-address register number is steered to that thread's guest copy.

Top module: `evu_top`

## Requirements
- R1: One cycle after a cycle with `exc_valid` high, `vec_valid` is high and `vec_addr` equals the selected 52-bit base in bits 63:12 followed by the offset in bits 11:0. `vec_valid` is low in every other cycle.
- R2: The base is the host base of thread `exc_tid` when `guest_state[exc_tid]` is 0, and that thread's guest base when it is 1.
- R3: `exc_type` codes map to offsets as follows: 0 machine check 0x000, 1 critical input 0x020, 2 debug 0x040, 3 data storage 0x060, 4 instruction storage 0x080, 5 external input 0x0A0, 6 alignment 0x0C0, 7 data TLB miss 0x060.
- R4: An exception of type 3, 6 or 7 with `exc_to_guest` high loads `exc_ea` into the guest fault-address register of thread `exc_tid`. Types 0, 1, 2, 4 and 5 capture nothing.
- R5: A type 3, 6 or 7 exception with `exc_to_guest` low loads `exc_ea` into the host fault-address register, and the guest copy keeps its value.
- R6: Register numbers are 63 for the host base, 447 for the guest base, 61 for the host fault address and 381 for the guest fault address. While `guest_state[spr_tid]` is 1, reads and writes of number 61 access the guest fault-address register.
- R7: After reset, all registers of every thread read as zero, along with `vec_addr` and `vec_valid`. `spr_rdata` shows the addressed register in the same cycle that `spr_rd` is high, and a write becomes visible from the next cycle.
- R8: An access with `spr_priv` low to any of the four numbers drives `spr_priv_err` high in that cycle and `spr_rdata` to zero, and it changes no register.
- R9: A write to a base register stores bits 63:12 of `spr_wdata`. Bits 11:0 are dropped, so the low 4 bits and the rest of the low 12 read back as zero and vectors stay aligned.
- R10: When a hardware capture and a software write target the same fault-address register in the same cycle, the captured address is kept.
- R11: Each thread's registers are separate. An exception or write for one thread leaves the other thread's registers unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| exc_valid | input | 1 | Exception request |
| exc_type | input | 3 | Exception kind code |
| exc_tid | input | TID_W (1) | Thread of the exception |
| exc_ea | input | 64 | Faulting effective address |
| exc_to_guest | input | 1 | Exception is directed to the guest |
| guest_state | input | NTHREADS (2) | Current guest-state bit per thread |
| spr_wr | input | 1 | Register write strobe |
| spr_rd | input | 1 | Register read strobe |
| spr_priv | input | 1 | Access is privileged |
| spr_tid | input | TID_W (1) | Thread of the register access |
| spr_num | input | 10 | Register number |
| spr_wdata | input | 64 | Write data |
| spr_rdata | output | 64 | Read data (combinational) |
| spr_priv_err | output | 1 | Privilege violation on this access |
| vec_valid | output | 1 | Vector address valid |
| vec_addr | output | 64 | Handler vector address |

## Verification
The vector is due exactly one clock after the exception request. The bench drives the request on a falling edge and compares `vec_addr` at the next falling edge, after the single rising edge that registers it. Fault-address captures and register writes land on that same rising edge, so they are read back through the move port on a later falling edge. Reads and the privilege flag are combinational, so they are sampled 1 ns after the inputs change and before the following rising edge. The sweep covers every kind, both guest-state values, both routings and both threads. The expected value of each check is computed arithmetically from the offset rule and a shadow model of the registers.

// File: rtl/evu_pkg.sv
package evu_pkg;

  localparam logic [2:0] K_MCHK  = 3'd0;
  localparam logic [2:0] K_CRIT  = 3'd1;
  localparam logic [2:0] K_DBG   = 3'd2;
  localparam logic [2:0] K_DSTOR = 3'd3;
  localparam logic [2:0] K_ISTOR = 3'd4;
  localparam logic [2:0] K_EXT   = 3'd5;
  localparam logic [2:0] K_ALIGN = 3'd6;
  localparam logic [2:0] K_DTLB  = 3'd7;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_HPFX,
    SEL_GPFX,
    SEL_HDEA,
    SEL_GDEA
  } spr_sel_e;

  // R3: fixed handler offset per exception kind
  function automatic logic [11:0] vec_offset(input logic [2:0] kind);
    logic [11:0] off;
    case (kind)
      K_MCHK:  off = 12'h000;
      K_CRIT:  off = 12'h020;
      K_DBG:   off = 12'h040;
      K_DSTOR: off = 12'h060;
      K_ISTOR: off = 12'h080;
      K_EXT:   off = 12'h0A0;
      K_ALIGN: off = 12'h0C0;
      default: off = 12'h060;
    endcase
    return off;
  endfunction

  // R4: kinds that record the faulting data address
  function automatic logic is_data_side(input logic [2:0] kind);
    return (kind == K_DSTOR) || (kind == K_ALIGN) || (kind == K_DTLB);
  endfunction

  // R1: base in the upper bits, offset in the low 12
  function automatic logic [63:0] make_vector(input logic [51:0] base,
                                              input logic [2:0] kind);
    return {base, vec_offset(kind)};
  endfunction

endpackage

// File: rtl/evu_spr_decode.sv
module evu_spr_decode
  import evu_pkg::*;
#(
  parameter int NUM_W     = 10,
  parameter int NUM_HPFX  = 63,
  parameter int NUM_GPFX  = 447,
  parameter int NUM_HDEA  = 61,
  parameter int NUM_GDEA  = 381
) (
  input  logic [NUM_W-1:0] num,
  input  logic             in_guest,
  output spr_sel_e         sel,
  output logic             hit
);

  always_comb begin
    sel = SEL_NONE;
    if (num == NUM_W'(NUM_HPFX))      sel = SEL_HPFX;
    else if (num == NUM_W'(NUM_GPFX)) sel = SEL_GPFX;
    else if (num == NUM_W'(NUM_GDEA)) sel = SEL_GDEA;
    else if (num == NUM_W'(NUM_HDEA)) sel = in_guest ? SEL_GDEA : SEL_HDEA; // R6
  end

  assign hit = (sel != SEL_NONE);

  // R6
  always_comb begin
    redirect_chk: assert (!(in_guest && num == NUM_W'(NUM_HDEA)) || sel == SEL_GDEA);
  end

endmodule

// File: rtl/evu_thread_regs.sv
module evu_thread_regs
  import evu_pkg::*;
#(
  parameter int XLEN  = 64,
  parameter int PFX_W = 52
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cap_en,
  input  logic             cap_guest,
  input  logic [XLEN-1:0]  cap_ea,
  input  logic             wr_en,
  input  spr_sel_e         wr_sel,
  input  logic [XLEN-1:0]  wr_data,
  output logic [PFX_W-1:0] hpfx,
  output logic [PFX_W-1:0] gpfx,
  output logic [XLEN-1:0]  hdea,
  output logic [XLEN-1:0]  gdea
);

  localparam int OFF_W = XLEN - PFX_W;

  logic cap_host_evt, cap_guest_evt;
  assign cap_host_evt  = cap_en && !cap_guest;
  assign cap_guest_evt = cap_en && cap_guest;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hpfx <= '0;
      gpfx <= '0;
      hdea <= '0;
      gdea <= '0;
    end else begin
      // R9: low OFF_W bits of a written base are dropped
      if (wr_en && wr_sel == SEL_HPFX) hpfx <= wr_data[XLEN-1:OFF_W];
      if (wr_en && wr_sel == SEL_GPFX) gpfx <= wr_data[XLEN-1:OFF_W];
      // R10: capture wins over a same-cycle write
      if (cap_host_evt)                     hdea <= cap_ea;
      else if (wr_en && wr_sel == SEL_HDEA) hdea <= wr_data;
      if (cap_guest_evt)                    gdea <= cap_ea;
      else if (wr_en && wr_sel == SEL_GDEA) gdea <= wr_data;
    end
  end

  // R4 R10
  gdea_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cap_guest_evt |=> gdea == $past(cap_ea));

  // R5
  host_cap_keeps_guest_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cap_host_evt && !(wr_en && wr_sel == SEL_GDEA) |=> $stable(gdea) && hdea == $past(cap_ea));

  // R9
  pfx_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && wr_sel == SEL_GPFX |=> gpfx == $past(wr_data[XLEN-1:OFF_W]));

endmodule

// File: rtl/evu_vec_gen.sv
module evu_vec_gen
  import evu_pkg::*;
#(
  parameter int XLEN  = 64,
  parameter int PFX_W = 52
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req,
  input  logic [2:0]       kind,
  input  logic             use_guest,
  input  logic [PFX_W-1:0] hpfx,
  input  logic [PFX_W-1:0] gpfx,
  output logic             vld,
  output logic [XLEN-1:0]  addr
);

  logic [PFX_W-1:0] base_sel;
  assign base_sel = use_guest ? gpfx : hpfx; // R2

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld  <= 1'b0;
      addr <= '0;
    end else begin
      vld <= req;
      if (req) addr <= make_vector(base_sel, kind);
    end
  end

  // R1
  vec_timing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req |=> vld);

  // R3
  vec_offset_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vld |-> addr[11:8] == 4'h0 && addr[4:0] == 5'h0);

endmodule

// File: rtl/evu_top.sv
module evu_top
  import evu_pkg::*;
#(
  parameter int NTHREADS = 2,
  parameter int XLEN     = 64,
  parameter int PFX_W    = 52,
  parameter int NUM_W    = 10,
  parameter int NUM_HPFX = 63,
  parameter int NUM_GPFX = 447,
  parameter int NUM_HDEA = 61,
  parameter int NUM_GDEA = 381,
  localparam int TID_W   = (NTHREADS > 1) ? $clog2(NTHREADS) : 1,
  localparam int OFF_W   = XLEN - PFX_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                exc_valid,
  input  logic [2:0]          exc_type,
  input  logic [TID_W-1:0]    exc_tid,
  input  logic [XLEN-1:0]     exc_ea,
  input  logic                exc_to_guest,
  input  logic [NTHREADS-1:0] guest_state,
  input  logic                spr_wr,
  input  logic                spr_rd,
  input  logic                spr_priv,
  input  logic [TID_W-1:0]    spr_tid,
  input  logic [NUM_W-1:0]    spr_num,
  input  logic [XLEN-1:0]     spr_wdata,
  output logic [XLEN-1:0]     spr_rdata,
  output logic                spr_priv_err,
  output logic                vec_valid,
  output logic [XLEN-1:0]     vec_addr
);

  logic [PFX_W-1:0] hpfx_a [NTHREADS];
  logic [PFX_W-1:0] gpfx_a [NTHREADS];
  logic [XLEN-1:0]  hdea_a [NTHREADS];
  logic [XLEN-1:0]  gdea_a [NTHREADS];

  spr_sel_e sel;
  logic     hit, wr_ok, rd_ok, data_evt;

  evu_spr_decode #(
    .NUM_W(NUM_W), .NUM_HPFX(NUM_HPFX), .NUM_GPFX(NUM_GPFX),
    .NUM_HDEA(NUM_HDEA), .NUM_GDEA(NUM_GDEA)
  ) u_dec (
    .num      (spr_num),
    .in_guest (guest_state[spr_tid]),
    .sel      (sel),
    .hit      (hit)
  );

  assign spr_priv_err = (spr_wr || spr_rd) && hit && !spr_priv; // R8
  assign wr_ok        = spr_wr && hit && spr_priv;
  assign rd_ok        = spr_rd && hit && spr_priv;
  assign data_evt     = exc_valid && is_data_side(exc_type);

  for (genvar i = 0; i < NTHREADS; i++) begin : g_thr
    logic mine_exc, mine_spr;
    assign mine_exc = (exc_tid == TID_W'(i));
    assign mine_spr = (spr_tid == TID_W'(i));

    evu_thread_regs #(.XLEN(XLEN), .PFX_W(PFX_W)) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .cap_en    (data_evt && mine_exc),
      .cap_guest (exc_to_guest),
      .cap_ea    (exc_ea),
      .wr_en     (wr_ok && mine_spr),
      .wr_sel    (sel),
      .wr_data   (spr_wdata),
      .hpfx      (hpfx_a[i]),
      .gpfx      (gpfx_a[i]),
      .hdea      (hdea_a[i]),
      .gdea      (gdea_a[i])
    );

    // R8 R11
    priv_no_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
      spr_priv_err && !exc_valid |=> $stable(gdea_a[i]) && $stable(hdea_a[i])
                                     && $stable(hpfx_a[i]) && $stable(gpfx_a[i]));
  end

  evu_vec_gen #(.XLEN(XLEN), .PFX_W(PFX_W)) u_vec (
    .clk       (clk),
    .rst_n     (rst_n),
    .req       (exc_valid),
    .kind      (exc_type),
    .use_guest (guest_state[exc_tid]),
    .hpfx      (hpfx_a[exc_tid]),
    .gpfx      (gpfx_a[exc_tid]),
    .vld       (vec_valid),
    .addr      (vec_addr)
  );

  // R7: combinational read mux
  always_comb begin
    spr_rdata = '0;
    if (rd_ok) begin
      case (sel)
        SEL_HPFX: spr_rdata = {hpfx_a[spr_tid], {OFF_W{1'b0}}};
        SEL_GPFX: spr_rdata = {gpfx_a[spr_tid], {OFF_W{1'b0}}};
        SEL_HDEA: spr_rdata = hdea_a[spr_tid];
        SEL_GDEA: spr_rdata = gdea_a[spr_tid];
        default:  spr_rdata = '0;
      endcase
    end
  end

  // R8
  priv_rdata_chk: assert property (@(posedge clk) disable iff (!rst_n)
    spr_priv_err |-> spr_rdata == '0);

endmodule

// File: tb/tb_evu_top.sv
`timescale 1ns/1ps
module tb_evu_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        exc_valid = 1'b0;
  logic [2:0]  exc_type = '0;
  logic [0:0]  exc_tid = '0;
  logic [63:0] exc_ea = '0;
  logic        exc_to_guest = 1'b0;
  logic [1:0]  guest_state = '0;
  logic        spr_wr = 1'b0, spr_rd = 1'b0, spr_priv = 1'b0;
  logic [0:0]  spr_tid = '0;
  logic [9:0]  spr_num = '0;
  logic [63:0] spr_wdata = '0;
  logic [63:0] spr_rdata;
  logic        spr_priv_err;
  logic        vec_valid;
  logic [63:0] vec_addr;

  localparam logic [9:0] N_HP = 10'd63, N_GP = 10'd447, N_HD = 10'd61, N_GD = 10'd381;

  int tests = 0, fails = 0;
  bit done = 1'b0;

  logic [63:0] m_hp [2], m_gp [2], m_hd [2], m_gd [2];

  evu_top dut (
    .clk(clk), .rst_n(rst_n), .exc_valid(exc_valid), .exc_type(exc_type),
    .exc_tid(exc_tid), .exc_ea(exc_ea), .exc_to_guest(exc_to_guest),
    .guest_state(guest_state), .spr_wr(spr_wr), .spr_rd(spr_rd),
    .spr_priv(spr_priv), .spr_tid(spr_tid), .spr_num(spr_num),
    .spr_wdata(spr_wdata), .spr_rdata(spr_rdata), .spr_priv_err(spr_priv_err),
    .vec_valid(vec_valid), .vec_addr(vec_addr)
  );

  always #2.5 clk = ~clk;

  task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic rd(input int t, input logic [9:0] n, input bit p,
                    output logic [63:0] d, output logic e);
    @(negedge clk);
    spr_tid = t[0:0]; spr_num = n; spr_priv = p; spr_rd = 1'b1;
    #1;
    d = spr_rdata; e = spr_priv_err;
    spr_rd = 1'b0;
  endtask

  task automatic wr(input int t, input logic [9:0] n, input bit p,
                    input logic [63:0] v, output logic e);
    @(negedge clk);
    spr_tid = t[0:0]; spr_num = n; spr_priv = p; spr_wdata = v; spr_wr = 1'b1;
    #1;
    e = spr_priv_err;
    @(posedge clk);
    #1 spr_wr = 1'b0;
  endtask

  function automatic logic [63:0] offs(input int k);
    return (k <= 6) ? 64'(k * 32) : 64'h60;
  endfunction

  task automatic check_deas(input string req, input int t);
    logic [63:0] d; logic e;
    rd(t, N_HD, 1'b1, d, e); check(req, d, m_hd[t]);
    rd(t, N_GD, 1'b1, d, e); check(req, d, m_gd[t]);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [63:0] d; logic e;
    for (int t = 0; t < 2; t++) begin
      m_hp[t] = '0; m_gp[t] = '0; m_hd[t] = '0; m_gd[t] = '0;
    end
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R7: reset values
    @(negedge clk);
    check("R7 vec_valid", {63'd0, vec_valid}, 64'd0);
    check("R7 vec_addr", vec_addr, 64'd0);
    for (int t = 0; t < 2; t++) begin
      rd(t, N_HP, 1'b1, d, e); check("R7 hpfx", d, 64'd0);
      rd(t, N_GP, 1'b1, d, e); check("R7 gpfx", d, 64'd0);
      check_deas("R7 dea", t);
    end

    // R9: base writes drop bits 11:0
    for (int t = 0; t < 2; t++) begin
      logic [63:0] hv, gv;
      hv = 64'hA5A5_1234_5678_9FFF ^ (64'(t) << 40);
      gv = 64'h3C3C_8765_4321_0ABF ^ (64'(t) << 36);
      wr(t, N_HP, 1'b1, hv, e); m_hp[t] = {hv[63:12], 12'h0};
      wr(t, N_GP, 1'b1, gv, e); m_gp[t] = {gv[63:12], 12'h0};
      rd(t, N_HP, 1'b1, d, e); check("R9 hpfx low bits", d, m_hp[t]);
      rd(t, N_GP, 1'b1, d, e); check("R9 gpfx low bits", d, m_gp[t]);
    end

    // R1 R2 R3 R4 R5 R11: sweep
    for (int t = 0; t < 2; t++)
      for (int gs = 0; gs < 2; gs++)
        for (int tg = 0; tg < 2; tg++)
          for (int k = 0; k < 8; k++) begin
            logic [63:0] ea, expv;
            ea = 64'hF00D_0000_0000_0001 + (64'(t*32 + gs*16 + tg*8 + k) << 4);
            @(negedge clk);
            guest_state = 2'(gs) << t;
            exc_valid = 1'b1; exc_type = 3'(k); exc_tid = t[0:0];
            exc_ea = ea; exc_to_guest = tg[0];
            @(negedge clk);
            exc_valid = 1'b0;
            expv = ((gs != 0) ? m_gp[t] : m_hp[t]) | offs(k);
            check("R1 vec_valid", {63'd0, vec_valid}, 64'd1);
            check("R1 R2 R3 vec_addr", vec_addr, expv);
            if (k == 3 || k >= 6) begin
              if (tg != 0) m_gd[t] = ea; else m_hd[t] = ea;
            end
            guest_state = '0;
            @(negedge clk);
            check("R1 vec_valid drops", {63'd0, vec_valid}, 64'd0);
            check_deas("R4 R5 capture", t);
            check_deas("R11 other thread", 1 - t);
          end

    // R6: redirect of host number in guest state
    guest_state = 2'b01;
    rd(0, N_HD, 1'b1, d, e); check("R6 read redirect", d, m_gd[0]);
    wr(0, N_HD, 1'b1, 64'h1111_2222_3333_4444, e); m_gd[0] = 64'h1111_2222_3333_4444;
    guest_state = 2'b00;
    check_deas("R6 write redirect", 0);
    rd(1, N_HD, 1'b1, d, e); check("R6 thread1 host", d, m_hd[1]);

    // R8: unprivileged accesses
    wr(1, N_GD, 1'b0, 64'hDEAD_BEEF_0000_0000, e);
    check("R8 write err", {63'd0, e}, 64'd1);
    wr(1, N_HP, 1'b0, 64'hFFFF_FFFF_FFFF_FFFF, e);
    check("R8 write err pfx", {63'd0, e}, 64'd1);
    rd(1, N_GD, 1'b0, d, e);
    check("R8 read err", {63'd0, e}, 64'd1);
    check("R8 read data zero", d, 64'd0);
    check_deas("R8 unchanged", 1);
    rd(1, N_HP, 1'b1, d, e); check("R8 pfx unchanged", d, m_hp[1]);
    rd(1, N_GD, 1'b1, d, e); check("R8 priv no err", {63'd0, e}, 64'd0);

    // R10: capture beats write on same register
    @(negedge clk);
    exc_valid = 1'b1; exc_type = 3'd6; exc_tid = 1'b1; exc_to_guest = 1'b1;
    exc_ea = 64'h7777_0000_AAAA_0008;
    spr_tid = 1'b1; spr_num = N_GD; spr_priv = 1'b1; spr_wr = 1'b1;
    spr_wdata = 64'h0BAD_0BAD_0BAD_0BAD;
    @(posedge clk);
    #1 exc_valid = 1'b0; spr_wr = 1'b0;
    m_gd[1] = 64'h7777_0000_AAAA_0008;
    check_deas("R10 capture wins", 1);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule